// File: doc/BRIEF.md
# Machine-Mode Counter and Control Register Unit

This block holds the machine-mode performance counters of a 32-bit RISC-V core and serves the core's CSR instructions against them. For each access the core presents a 12-bit CSR address, an operation (read, write, set bits, clear bits), an operand, a flag saying the operand came from register x0 or from a zero immediate, a valid strobe and a stall signal. The block returns the current value of the addressed register at once, combinationally, and raises an illegal-instruction flag when the access is not allowed. Any update lands on the next clock edge.

The counters are a cycle counter, a retired-instruction counter and a parameterised number of hardware event counters, starting at index 3. Each is 64 bits wide and is reached as two 32-bit halves. A counter-inhibit register freezes individual counters. Event selector registers are hardwired. Event counter indices past the configured count read as zero and cannot be changed. Events arrive as single-cycle input pulses.

Top module: `csr_perf_unit`

## Requirements
- R1: Counter index n (0..31, except 1) reads its low half at address 0xB00+n and its high half at 0xB80+n. Index 0 is the cycle counter, index 2 is the retired-instruction counter, and index 3+k is event counter k.
- R2: The cycle counter increments every cycle, the retired-instruction counter increments on instr_ret_i, and event counter 3+k increments on hpm_event_i[k]. The low half carries into the high half.
- R3: Bit n of the inhibit register at 0x320 freezes counter n. Only the bits of implemented counters can be set; the other bits read as 0.
- R4: csr_op_i encodes read=0, write=1, set=2 and clear=3. A write stores the operand. Set ORs the operand into the register. Clear clears exactly the operand's one bits.
- R5: Set or clear with csr_src_zero_i=1 changes nothing and is a legal read.
- R6: Addresses outside the map, including index 1 at 0xB01, 0xB81, 0xC01 and 0xC81, raise illegal_o.
- R7: 0xC00+n and 0xC80+n are read-only views of counter n. Any access that would change a view raises illegal_o and changes no state. Set or clear on a view with csr_src_zero_i=1 is a legal read.
- R8: While stall_i holds the same instruction, its write, set or clear changes the register in one cycle only. The counter keeps counting in the later stalled cycles.
- R9: A write to a counter half wins over an increment in the same cycle, and the other half keeps its value.
- R10: Event counter indices at or beyond 3+NUM_HPM read as 0, and writes to them have no effect.
- R11: Selector 0x320+n (n = 3..31) reads n if counter n is implemented and 0 otherwise. Writes to it are legal and have no effect.
- R12: After reset, all counters and the inhibit register are 0.
- R13: illegal_o is 0 whenever csr_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_valid_i | input | 1 | A CSR instruction is presented |
| stall_i | input | 1 | The same instruction is presented again next cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | 32 | Operand |
| csr_src_zero_i | input | 1 | Operand came from x0 or a zero immediate |
| instr_ret_i | input | 1 | An instruction retired this cycle |
| hpm_event_i | input | NUM_HPM | Event pulses for counters 3 and up |
| csr_rdata_o | output | 32 | Value of the addressed register |
| illegal_o | output | 1 | The access raises an illegal-instruction exception |

## Verification
The bench first reads the registers right after reset. It then runs plain writes, set and clear masks with overlapping bits, and the same set or clear with the zero-source flag. The last case separates a real no-op from one that changes state. Writes arrive on free-running, inhibited and event-pulsed counters, so a write that wins over an increment can be told from one that loses to it. A low half of all ones shows the carry into the high half. A write held over several stalled cycles while events pulse shows whether it landed once or again on every cycle. Accesses to the read-only views, index 1, foreign addresses, the selectors and unimplemented indices exercise each branch of the legality decode.

// File: rtl/csr_perf_pkg.sv
package csr_perf_pkg;

  typedef enum logic [1:0] {
    CSR_READ  = 2'd0,
    CSR_WRITE = 2'd1,
    CSR_SET   = 2'd2,
    CSR_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_CNT_RO,
    SEL_INHIBIT,
    SEL_EVENT
  } csr_sel_e;

  localparam logic [11:0] CNT_MASK   = 12'hF60;
  localparam logic [11:0] CNT_M_BASE = 12'hB00;
  localparam logic [11:0] CNT_U_BASE = 12'hC00;
  localparam logic [11:0] EVT_MASK   = 12'hFE0;
  localparam logic [11:0] EVT_BASE   = 12'h320;

  function automatic logic [31:0] apply_op(csr_op_e op, logic [31:0] old, logic [31:0] opnd);
    case (op)
      CSR_WRITE: return opnd;
      CSR_SET:   return old | opnd;
      CSR_CLEAR: return old & ~opnd;
      default:   return old;
    endcase
  endfunction

  function automatic logic [63:0] counter_next(logic [63:0] cur, logic we_lo, logic we_hi,
                                               logic [31:0] wv, logic inc);
    if (we_lo)      return {cur[63:32], wv};
    else if (we_hi) return {wv, cur[31:0]};
    else if (inc)   return cur + 64'd1;
    else            return cur;
  endfunction

  function automatic logic counter_present(int idx, int n_hpm);
    return (idx == 0) || (idx == 2) || (idx >= 3 && idx < 3 + n_hpm);
  endfunction

  function automatic logic [31:0] impl_mask(int n_hpm);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = counter_present(i, n_hpm);
    return m;
  endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_perf_pkg::*;
(
  input  logic        valid_i,
  input  logic [11:0] addr_i,
  input  csr_op_e     op_i,
  input  logic        src_zero_i,
  output csr_sel_e    sel_o,
  output logic [4:0]  idx_o,
  output logic        hi_o,
  output logic        wr_req_o,
  output logic        illegal_o
);

  always_comb begin
    idx_o = addr_i[4:0];
    hi_o  = addr_i[7];
    sel_o = SEL_NONE;
    if ((addr_i & CNT_MASK) == CNT_M_BASE && idx_o != 5'd1) begin
      sel_o = SEL_CNT;
    end else if ((addr_i & CNT_MASK) == CNT_U_BASE && idx_o != 5'd1) begin
      sel_o = SEL_CNT_RO;
    end else if ((addr_i & EVT_MASK) == EVT_BASE) begin
      if (idx_o == 5'd0)      sel_o = SEL_INHIBIT;
      else if (idx_o >= 5'd3) sel_o = SEL_EVENT;
    end
  end

  // set/clear with a zero operand source degrade to a pure read
  assign wr_req_o  = valid_i && (op_i != CSR_READ) &&
                     !(((op_i == CSR_SET) || (op_i == CSR_CLEAR)) && src_zero_i);
  assign illegal_o = valid_i && ((sel_o == SEL_NONE) || (sel_o == SEL_CNT_RO && wr_req_o));

endmodule

// File: rtl/csr_counter.sv
module csr_counter
  import csr_perf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_lo_i,
  input  logic        we_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        inc_i,
  output logic [63:0] value_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) value_o <= '0;
    else         value_o <= counter_next(value_o, we_lo_i, we_hi_i, wdata_i, inc_i);
  end

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i |=> value_o[31:0] == $past(wdata_i)); // R9
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hi_i |=> value_o[31:0] == $past(value_o[31:0])); // R9
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_lo_i && !we_hi_i && !inc_i) |=> $stable(value_o)); // R3

endmodule

// File: rtl/csr_perf_unit.sv
module csr_perf_unit
  import csr_perf_pkg::*;
#(
  parameter int NUM_HPM = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_valid_i,
  input  logic               stall_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [1:0]         csr_op_i,
  input  logic [31:0]        csr_wdata_i,
  input  logic               csr_src_zero_i,
  input  logic               instr_ret_i,
  input  logic [NUM_HPM-1:0] hpm_event_i,
  output logic [31:0]        csr_rdata_o,
  output logic               illegal_o
);

  localparam logic [31:0] IMPL_MASK = impl_mask(NUM_HPM);

  csr_op_e     op;
  csr_sel_e    sel;
  logic [4:0]  idx;
  logic        hi, wr_req, illegal;
  logic [31:0] rd_value, wval;
  logic        wr_fire, wr_done_q;
  logic [31:0] inhibit_q;
  logic [63:0] cnt_val [32];

  assign op = csr_op_e'(csr_op_i);

  csr_decode u_decode (
    .valid_i   (csr_valid_i),
    .addr_i    (csr_addr_i),
    .op_i      (op),
    .src_zero_i(csr_src_zero_i),
    .sel_o     (sel),
    .idx_o     (idx),
    .hi_o      (hi),
    .wr_req_o  (wr_req),
    .illegal_o (illegal)
  );

  always_comb begin
    case (sel)
      SEL_CNT, SEL_CNT_RO: rd_value = hi ? cnt_val[idx][63:32] : cnt_val[idx][31:0];
      SEL_INHIBIT:         rd_value = inhibit_q;
      SEL_EVENT:           rd_value = IMPL_MASK[idx] ? {27'd0, idx} : 32'd0;
      default:             rd_value = 32'd0;
    endcase
  end

  assign csr_rdata_o = rd_value;
  assign illegal_o   = illegal;
  assign wval        = apply_op(op, rd_value, csr_wdata_i);
  // one update per instruction, however long it stays stalled
  assign wr_fire     = wr_req && !illegal && !wr_done_q &&
                       (sel == SEL_CNT || sel == SEL_INHIBIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_done_q <= 1'b0;
      inhibit_q <= '0;
    end else begin
      wr_done_q <= stall_i && (wr_done_q || wr_fire);
      if (wr_fire && sel == SEL_INHIBIT) inhibit_q <= wval & IMPL_MASK;
    end
  end

  for (genvar i = 0; i < 32; i++) begin : g_cnt
    if (counter_present(i, NUM_HPM)) begin : g_impl
      logic ev;
      if (i == 0)      begin : g_cyc assign ev = 1'b1;             end
      else if (i == 2) begin : g_ret assign ev = instr_ret_i;      end
      else             begin : g_hpm assign ev = hpm_event_i[i-3]; end
      logic hit;
      assign hit = wr_fire && sel == SEL_CNT && idx == 5'(i);
      csr_counter u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_lo_i(hit && !hi),
        .we_hi_i(hit && hi),
        .wdata_i(wval),
        .inc_i  (ev && !inhibit_q[i]),
        .value_o(cnt_val[i])
      );
    end else begin : g_zero
      assign cnt_val[i] = '0;
    end
  end

  AST_ZERO_SRC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_op_i[1] && csr_src_zero_i) |-> !wr_fire); // R5
  AST_RO_VIEW_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_addr_i[11:8] == 4'hC && csr_addr_i[6:5] == 2'd0 &&
     csr_op_i == 2'd1) |-> illegal_o); // R7
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && stall_i) |=> !wr_fire); // R8
  AST_IDLE_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_valid_i |-> !illegal_o); // R13
  AST_INHIBIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_fire |=> $stable(inhibit_q)); // R3

endmodule

// File: tb/csr_perf_unit_tb_top.sv
`timescale 1ns/1ps
module csr_perf_unit_tb_top;

  localparam int NH = 4;

  logic        clk = 0, rst_n = 0;
  logic        v = 0, stall = 0, sz = 0, ret = 0;
  logic [11:0] addr = 0;
  logic [1:0]  op = 0;
  logic [31:0] wd = 0;
  logic [NH-1:0] ev = 0;
  logic [31:0] rdata;
  logic        ill;

  always #2 clk = ~clk;

  csr_perf_unit #(.NUM_HPM(NH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(v), .stall_i(stall),
    .csr_addr_i(addr), .csr_op_i(op), .csr_wdata_i(wd), .csr_src_zero_i(sz),
    .instr_ret_i(ret), .hpm_event_i(ev), .csr_rdata_o(rdata), .illegal_o(ill)
  );

  // ---- reference model written from the requirements ----
  logic [63:0] m_cnt [32];
  logic [31:0] m_inh;
  logic        m_done;

  function automatic logic m_present(int i);
    return i == 0 || i == 2 || (i >= 3 && i < 3 + NH);
  endfunction
  function automatic logic is_m(logic [11:0] a);
    return a[11:8] == 4'hB && a[6:5] == 2'd0 && a[4:0] != 5'd1;
  endfunction
  function automatic logic is_u(logic [11:0] a);
    return a[11:8] == 4'hC && a[6:5] == 2'd0 && a[4:0] != 5'd1;
  endfunction
  function automatic logic is_sel(logic [11:0] a);
    return a[11:5] == 7'h19;
  endfunction
  function automatic logic changes(logic [1:0] o, logic z);
    return o != 2'd0 && !(o[1] && z);
  endfunction
  function automatic logic b_illegal(logic vl, logic [11:0] a, logic [1:0] o, logic z);
    if (!vl) return 1'b0;
    if (is_m(a)) return 1'b0;
    if (is_u(a)) return changes(o, z);
    if (is_sel(a) && (a[4:0] == 5'd0 || a[4:0] >= 5'd3)) return 1'b0;
    return 1'b1;
  endfunction
  function automatic logic [31:0] b_read(logic [11:0] a);
    if (is_m(a) || is_u(a)) return a[7] ? m_cnt[a[4:0]][63:32] : m_cnt[a[4:0]][31:0];
    if (is_sel(a) && a[4:0] == 5'd0) return m_inh;
    if (is_sel(a)) return m_present(int'(a[4:0])) ? {27'd0, a[4:0]} : 32'd0;
    return 32'd0;
  endfunction
  function automatic logic [31:0] b_apply(logic [1:0] o, logic [31:0] old, logic [31:0] d);
    if (o == 2'd1) return d;
    if (o == 2'd2) return old | d;
    if (o == 2'd3) return old & ~d;
    return old;
  endfunction

  always @(posedge clk) begin
    logic fire;
    logic [31:0] nv;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_cnt[i] <= '0;
      m_inh <= '0; m_done <= 1'b0;
    end else begin
      fire = v && changes(op, sz) && !b_illegal(v, addr, op, sz) && !m_done &&
             (is_m(addr) || (is_sel(addr) && addr[4:0] == 5'd0));
      nv = b_apply(op, b_read(addr), wd);
      m_done <= stall && (m_done || fire);
      if (fire && is_sel(addr)) m_inh <= nv & 32'h0000_007D;
      for (int i = 0; i < 32; i++) begin
        if (m_present(i)) begin
          logic e;
          e = (i == 0) ? 1'b1 : (i == 2) ? ret : (i >= 3) ? ev[i-3] : 1'b0;
          if (fire && is_m(addr) && int'(addr[4:0]) == i)
            m_cnt[i] <= addr[7] ? {nv, m_cnt[i][31:0]} : {m_cnt[i][63:32], nv};
          else if (e && !m_inh[i])
            m_cnt[i] <= m_cnt[i] + 64'd1;
        end
      end
    end
  end

  // ---- scoreboard ----
  typedef struct { logic [31:0] rd; logic il; logic chk; string req; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (ill !== e.il) begin
          n_bad++;
          $display("FAIL %s illegal actual=%0b expected=%0b", e.req, ill, e.il);
        end else if (e.chk && rdata !== e.rd) begin
          n_bad++;
          $display("FAIL %s rdata actual=%08h expected=%08h", e.req, rdata, e.rd);
        end
      end
    end
  end

  task automatic access(input logic [11:0] a, input logic [1:0] o, input logic [31:0] d,
                        input logic z, input int nst, input string req);
    exp_t e;
    @(negedge clk);
    v = 1; addr = a; op = o; wd = d; sz = z; stall = (nst > 0);
    e.il = b_illegal(1'b1, a, o, z); e.rd = b_read(a); e.chk = !e.il; e.req = req;
    q.push_back(e);
    for (int k = 0; k < nst; k++) begin
      @(negedge clk);
      stall = (k < nst - 1);
    end
    @(negedge clk);
    v = 0; stall = 0; op = 0; sz = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    access(a, 2'd0, 32'd0, 1'b0, 0, req);
  endtask

  task automatic idle_check(input logic [11:0] a, input string req);
    exp_t e;
    @(negedge clk);
    v = 0; addr = a; op = 2'd1;
    e.il = 1'b0; e.rd = 0; e.chk = 0; e.req = req;
    q.push_back(e);
    @(negedge clk); op = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(12'hB02, "R12 minstret after reset");
    rd(12'h320, "R12 inhibit after reset");
    rd(12'hB00, "R1 mcycle runs");
    rd(12'hB80, "R1 mcycle high");
    // R3 inhibit mcycle and check it holds
    access(12'h320, 2'd1, 32'd1, 0, 0, "R3 inhibit write");
    rd(12'hB00, "R3 frozen read a");
    repeat (3) @(negedge clk);
    rd(12'hB00, "R3 frozen read b");
    access(12'h320, 2'd1, 32'hFFFF_FFFF, 0, 0, "R3 mask write");
    rd(12'h320, "R3 unimplemented bits read 0");
    access(12'h320, 2'd1, 32'd0, 0, 0, "R3 clear inhibit");
    // R2 carry
    access(12'hB00, 2'd1, 32'hFFFF_FFFE, 0, 0, "R2 preload low");
    repeat (4) @(negedge clk);
    rd(12'hB80, "R2 carry into high");
    rd(12'hB00, "R2 low wrapped");
    // R4 write/set/clear on hpm3
    access(12'hB03, 2'd1, 32'h0000_F0F0, 0, 0, "R4 write");
    access(12'hB03, 2'd2, 32'h0000_000F, 0, 0, "R4 set");
    access(12'hB03, 2'd3, 32'h0000_00F0, 0, 0, "R4 clear");
    rd(12'hB03, "R4 result F00F");
    // R5 zero source
    access(12'hB03, 2'd3, 32'hFFFF_FFFF, 1, 0, "R5 clear zero src");
    access(12'hB03, 2'd2, 32'hFFFF_FFFF, 1, 0, "R5 set zero src");
    rd(12'hB03, "R5 unchanged");
    // R7 read-only view
    rd(12'hC03, "R7 view read");
    access(12'hC03, 2'd1, 32'h1234, 0, 0, "R7 view write traps");
    access(12'hC83, 2'd2, 32'h1, 1, 0, "R7 view zero-src set legal");
    rd(12'hB03, "R7 state unchanged");
    // R6 unmapped
    rd(12'hB01, "R6 index1");
    rd(12'hC81, "R6 index1 view high");
    rd(12'h7FF, "R6 foreign");
    rd(12'h321, "R6 selector 1");
    // R8 stalled write with events pulsing
    ev = 4'b0001;
    access(12'hB03, 2'd1, 32'd5, 0, 3, "R8 stalled write");
    ev = 0;
    rd(12'hB03, "R8 written once then counted");
    access(12'hB04, 2'd2, 32'h1, 0, 4, "R8 stalled set");
    rd(12'hB04, "R8 set once");
    // R9 write over increment; high half alone
    ret = 1;
    access(12'hB02, 2'd1, 32'hAAAA_0000, 0, 0, "R9 write vs retire");
    ret = 0;
    rd(12'hB02, "R9 low written");
    access(12'hB82, 2'd1, 32'h0000_0077, 0, 0, "R9 high write");
    rd(12'hB82, "R9 high");
    rd(12'hB02, "R9 low kept");
    // R10 unimplemented counter
    access(12'hB0A, 2'd1, 32'hDEAD, 0, 0, "R10 write ignored");
    rd(12'hB0A, "R10 reads zero");
    rd(12'hB8A, "R10 high zero");
    // R11 selectors
    rd(12'h324, "R11 selector implemented");
    rd(12'h32A, "R11 selector unimplemented");
    access(12'h324, 2'd1, 32'hFF, 0, 0, "R11 write legal");
    rd(12'h324, "R11 unchanged");
    // R13
    idle_check(12'h7FF, "R13 no valid");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule